// File: doc/BRIEF.md
# Burst SRAM Cycle Controller

This block is the cycle engine of a synchronous burst SRAM that needs no idle cycle when the bus turns from reading to writing. On every enabled rising clock edge it decodes a chip select, a load/advance select, a write strobe and two active-low byte-lane strobes into a read, a write or a deselect. It runs a four-beat burst address sequence, and it owns an internal 18-bit memory array built from two 9-bit lanes. The command issued at one edge has its data phase in the following clock interval. The master samples read data, and the block captures write data, at the second enabled edge after the address edge. Because of this, reads and writes can alternate on consecutive cycles.

Two inputs take precedence over the command decode. An active-high stall input makes the block ignore the clock edge, so all pipeline, burst and array state is held. A sleep input puts the block into a low-power state through a two-edge entry and a two-edge recovery. The active-low output enable is combinational: it gates the read drive within the current cycle, and it is masked during every write data phase.

The state machine has six states. ST_DESEL is idle, ST_RBURST is an open read burst, ST_WBURST is an open write burst, ST_ZZ_ENTER is the first sleep edge, ST_ZZ_DOZE is asleep, and ST_ZZ_REC is recovery. The transitions are as follows. Sleep high at an edge moves any non-sleep state to ST_ZZ_ENTER, and moves ST_ZZ_ENTER or ST_ZZ_DOZE to ST_ZZ_DOZE. With sleep low, ST_ZZ_ENTER and ST_ZZ_DOZE go to ST_ZZ_REC, and ST_ZZ_REC goes to ST_DESEL. In the other states a stalled edge holds the state. A load (advance low) goes to ST_DESEL, ST_RBURST or ST_WBURST according to the select and write strobe. An advance keeps the current state.

Top module: `sbs_sram_ctrl`

## Requirements
- R1: A load with sel_n high, or an advance (adv=1) while no burst is open, is a deselect: no lane is written and the bus is not driven in its data phase.
- R2: A load with sel_n=0 and wr_n=1 begins a read burst at addr. The word is driven on dq_out (dq_drive=1) throughout the interval after the next enabled edge. An advance in a read burst reads the next burst address.
- R3: A load with sel_n=0 and wr_n=0 begins a write burst. The bit lane_n[0]=0 writes dq bits 8:0 and lane_n[1]=0 writes bits 17:9, using din sampled at the second enabled edge after the address edge. With lane_n=2'b11 the cycle is a write abort and nothing is written.
- R4: During a write data phase lane_we equals the inverted lane_n of that command, and dq_drive stays 0 whatever out_en_n is.
- R5: With the default interleaved order, beat n of a burst (n=0..3) uses the load address with its two low bits XORed with n. The linear variant adds n modulo 4 instead.
- R6: With stall=1 the edge is ignored: no command is accepted, no write is committed, and outputs and pending data phases hold.
- R7: out_en_n acts without a clock edge. A read whose data phase sees out_en_n=1 is a dummy read that still advances the burst.
- R8: sleep=1 drops dq_drive and lane_we at once and abandons in-flight commands. asleep rises after the second consecutive edge with sleep high.
- R9: After sleep falls, the commands sampled at the first two edges are ignored. The third edge accepts commands normally.
- R10: After reset, dq_drive=0, lane_we=0 and asleep=0, even with out_en_n=0.
- R11: A read of the address written by the immediately preceding command returns the newly written data.
- R12: Reads and writes may alternate on consecutive edges with no idle cycle, each with correct data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select, sampled on a load |
| adv | input | 1 | 0 = load a new address, 1 = advance the open burst |
| wr_n | input | 1 | Active-low write strobe, sampled on a load |
| lane_n | input | 2 | Active-low lane write strobes; bit 0 = bits 8:0, bit 1 = bits 17:9 |
| stall | input | 1 | High ignores the clock edge |
| sleep | input | 1 | Low-power request |
| out_en_n | input | 1 | Asynchronous active-low read output enable |
| addr | input | 6 | Word address for a load |
| din | input | 18 | Write data, sampled at the commit edge |
| dq_out | output | 18 | Read data, zero when not driving |
| dq_drive | output | 1 | Bus drive enable |
| lane_we | output | 2 | Lane write mask of the current write data phase |
| asleep | output | 1 | Low-power state reached |

## Verification
The assertions assume that every control input settles away from the rising edge. They also assume that sleep is low while reset is released, so asleep can only rise after an edge that sampled sleep high. The bench changes all inputs half a period after the rising edge and holds sleep low through reset. It moves out_en_n between edges only where the asynchronous path is under test. It writes every address before reading it, so every expected value is defined.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [2:0] {
        ST_DESEL,
        ST_RBURST,
        ST_WBURST,
        ST_ZZ_ENTER,
        ST_ZZ_DOZE,
        ST_ZZ_REC
    } sbs_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE
    } sbs_op_e;

endpackage

// File: rtl/sbs_cycle_fsm.sv
module sbs_cycle_fsm
    import sbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel_n,
    input  logic    adv,
    input  logic    wr_n,
    input  logic    stall,
    input  logic    sleep,
    output sbs_op_e op,
    output logic    begin_burst,
    output logic    cont_burst,
    output logic    zz_any,
    output logic    asleep
);

    sbs_state_e state_q;
    sbs_state_e state_d;
    logic       in_zz;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (sleep) begin
            state_d = (state_q == ST_ZZ_ENTER || state_q == ST_ZZ_DOZE)
                      ? ST_ZZ_DOZE : ST_ZZ_ENTER;
        end else begin
            unique case (state_q)
                ST_ZZ_ENTER, ST_ZZ_DOZE: state_d = ST_ZZ_REC;
                ST_ZZ_REC:               state_d = ST_DESEL;
                default: begin
                    if (!stall && !adv) begin
                        if (sel_n)      state_d = ST_DESEL;
                        else if (wr_n)  state_d = ST_RBURST;
                        else            state_d = ST_WBURST;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        in_zz       = (state_q == ST_ZZ_ENTER) || (state_q == ST_ZZ_DOZE) ||
                      (state_q == ST_ZZ_REC);
        zz_any      = sleep | in_zz;
        asleep      = (state_q == ST_ZZ_DOZE);
        op          = OP_NONE;
        begin_burst = 1'b0;
        cont_burst  = 1'b0;
        if (!zz_any) begin
            if (!adv) begin
                if (!sel_n) begin
                    begin_burst = 1'b1;
                    op          = wr_n ? OP_READ : OP_WRITE;
                end
            end else begin
                unique case (state_q)
                    ST_RBURST: begin
                        op         = OP_READ;
                        cont_burst = 1'b1;
                    end
                    ST_WBURST: begin
                        op         = OP_WRITE;
                        cont_burst = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
    parameter int ADDR_W     = 6,
    parameter int INTERLEAVE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              begin_burst,
    input  logic              cont_burst,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int BEAT_W = 2;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_n;
    logic [BEAT_W-1:0] low_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (step_en) begin
            if (begin_burst) begin
                base_q <= ext_addr;
                beat_q <= '0;
            end else if (cont_burst) begin
                beat_q <= beat_n;
            end
        end
    end

    assign beat_n = beat_q + 2'd1;

    generate
        if (INTERLEAVE != 0) begin : g_xor_order
            assign low_n = base_q[BEAT_W-1:0] ^ beat_n;
        end else begin : g_lin_order
            assign low_n = base_q[BEAT_W-1:0] + beat_n;
        end
    endgenerate

    assign cur_addr = begin_burst ? ext_addr : {base_q[ADDR_W-1:BEAT_W], low_n};

endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic same_word;
    assign same_word = (waddr == raddr);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] cells [DEPTH];

            always_ff @(posedge clk) begin
                if (we[g]) begin
                    cells[waddr] <= wdata[g*LANE_W +: LANE_W];
                end
            end

            // bypass the lane being committed at this edge
            assign rdata[g*LANE_W +: LANE_W] = (we[g] && same_word)
                                               ? wdata[g*LANE_W +: LANE_W]
                                               : cells[raddr];
        end
    endgenerate

endmodule

// File: rtl/sbs_sram_ctrl.sv
module sbs_sram_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int LANE_W     = 9,
    parameter int LANES      = 2,
    parameter int INTERLEAVE = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n,
    input  logic                    adv,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    stall,
    input  logic                    sleep,
    input  logic                    out_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drive,
    output logic [LANES-1:0]        lane_we,
    output logic                    asleep
);

    localparam int DATA_W = LANES * LANE_W;

    sbs_op_e           op;
    logic              begin_burst;
    logic              cont_burst;
    logic              zz_any;
    logic              step_en;
    logic [ADDR_W-1:0] cur_addr;

    // address stage
    logic              s1_vld, s1_wr;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_mask;
    // data stage
    logic              s2_vld, s2_wr;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_mask;

    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] mem_rdata;
    logic [LANES-1:0]  mem_we;
    logic              commit;

    sbs_cycle_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n       (sel_n),
        .adv         (adv),
        .wr_n        (wr_n),
        .stall       (stall),
        .sleep       (sleep),
        .op          (op),
        .begin_burst (begin_burst),
        .cont_burst  (cont_burst),
        .zz_any      (zz_any),
        .asleep      (asleep)
    );

    assign step_en = !stall && !zz_any;

    sbs_burst_seq #(
        .ADDR_W     (ADDR_W),
        .INTERLEAVE (INTERLEAVE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (step_en),
        .begin_burst (begin_burst),
        .cont_burst  (cont_burst),
        .ext_addr    (addr),
        .cur_addr    (cur_addr)
    );

    assign commit = s2_vld && s2_wr && step_en;
    assign mem_we = commit ? s2_mask : '0;

    sbs_lane_mem #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (s2_addr),
        .wdata (din),
        .raddr (s1_addr),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_wr   <= 1'b0;
            s1_addr <= '0;
            s1_mask <= '0;
            s2_vld  <= 1'b0;
            s2_wr   <= 1'b0;
            s2_addr <= '0;
            s2_mask <= '0;
            rd_q    <= '0;
        end else if (zz_any) begin
            s1_vld <= 1'b0;
            s2_vld <= 1'b0;
        end else if (!stall) begin
            s1_vld  <= (op != OP_NONE);
            s1_wr   <= (op == OP_WRITE);
            s1_addr <= cur_addr;
            s1_mask <= (op == OP_WRITE) ? ~lane_n : '0;
            s2_vld  <= s1_vld;
            s2_wr   <= s1_wr;
            s2_addr <= s1_addr;
            s2_mask <= s1_mask;
            if (s1_vld && !s1_wr) begin
                rd_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        dq_drive = s2_vld && !s2_wr && !out_en_n && !sleep;
        dq_out   = dq_drive ? rd_q : '0;
        lane_we  = (s2_vld && s2_wr && !sleep) ? s2_mask : '0;
    end

endmodule

// File: rtl/sbs_sram_chk.sv
module sbs_sram_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall,
    input logic             sleep,
    input logic             out_en_n,
    input logic             dq_drive,
    input logic [LANES-1:0] lane_we,
    input logic             asleep
);

    // R4: bus never driven while a write data phase is open
    a_r4_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |-> !dq_drive);

    // R7: drive only with output enable active
    a_r7_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> !out_en_n);

    // R8: sleep request silences the bus and writes
    a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!dq_drive && lane_we == '0));

    // R8: asleep only follows a sampled sleep request
    a_r8_asleep_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(sleep));

    // R9: nothing happens while asleep
    a_r9_asleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (!dq_drive && lane_we == '0));

    // R6: a stalled edge keeps the write data phase
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !sleep && !asleep) |=> (sleep || $stable(lane_we)));

endmodule

bind sbs_sram_ctrl sbs_sram_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .sleep    (sleep),
    .out_en_n (out_en_n),
    .dq_drive (dq_drive),
    .lane_we  (lane_we),
    .asleep   (asleep)
);

// File: tb/sim_sbs_sram_ctrl.sv
module sim_sbs_sram_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_n, adv, wr_n, stall, sleep, out_en_n;
    logic [1:0]  lane_n;
    logic [5:0]  addr;
    logic [17:0] din;
    logic [17:0] dq_out;
    logic        dq_drive;
    logic [1:0]  lane_we;
    logic        asleep;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [17:0] D0 = 18'h0A001, D1 = 18'h0B102, D2 = 18'h1C203, D3 = 18'h2D304;
    localparam logic [17:0] E0 = 18'h11111, E1 = 18'h22222, E2 = 18'h33333;
    localparam logic [17:0] JUNK = 18'h3FFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbs_sram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .adv(adv), .wr_n(wr_n),
        .lane_n(lane_n), .stall(stall), .sleep(sleep), .out_en_n(out_en_n),
        .addr(addr), .din(din), .dq_out(dq_out), .dq_drive(dq_drive),
        .lane_we(lane_we), .asleep(asleep)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic s_n, input logic a, input logic w_n,
                        input logic [1:0] ln, input logic [5:0] ad, input logic [17:0] d);
        @(negedge clk);
        sel_n = s_n; adv = a; wr_n = w_n; lane_n = ln; addr = ad; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input logic [17:0] d);
        step(1'b1, 1'b0, 1'b1, 2'b11, 6'd0, d);
    endtask

    task automatic do_write(input logic [5:0] ad, input logic [17:0] d, input logic [1:0] ln);
        step(1'b0, 1'b0, 1'b0, ln, ad, JUNK);
        idle(JUNK);
        chk("R4 lane mask", {30'd0, lane_we}, {30'd0, ~ln});
        chk("R4 no drive in write", {31'd0, dq_drive}, 32'd0);
        idle(d);
    endtask

    task automatic do_read(input logic [5:0] ad, input logic [17:0] exp, input string req);
        step(1'b0, 1'b0, 1'b1, 2'b11, ad, JUNK);
        idle(JUNK);
        chk(req, {31'd0, dq_drive}, 32'd1);
        chk(req, {14'd0, dq_out}, {14'd0, exp});
    endtask

    task automatic t_reset;
        chk("R10 drive after reset", {31'd0, dq_drive}, 32'd0);
        chk("R10 lane_we after reset", {30'd0, lane_we}, 32'd0);
        chk("R10 asleep after reset", {31'd0, asleep}, 32'd0);
    endtask

    task automatic t_single;
        do_write(6'h05, D1, 2'b00);
        do_read(6'h05, D1, "R2 single read");
        idle(JUNK);
        chk("R1 idle no drive", {31'd0, dq_drive}, 32'd0);
    endtask

    task automatic t_lanes;
        do_write(6'h09, {9'h1A5, 9'h0C3}, 2'b00);
        do_write(6'h09, {9'h111, 9'h022}, 2'b10);
        do_read(6'h09, {9'h1A5, 9'h022}, "R3 lane A only");
        do_write(6'h09, {9'h0F0, 9'h1FF}, 2'b01);
        do_read(6'h09, {9'h0F0, 9'h022}, "R3 lane B only");
        do_write(6'h09, 18'h0, 2'b11);
        do_read(6'h09, {9'h0F0, 9'h022}, "R3 write abort");
    endtask

    task automatic t_burst;
        // write burst from 0x0E: interleaved beats 0x0E,0x0F,0x0C,0x0D
        step(1'b0, 1'b0, 1'b0, 2'b00, 6'h0E, JUNK);
        step(1'b1, 1'b1, 1'b0, 2'b00, 6'h00, JUNK);
        step(1'b1, 1'b1, 1'b0, 2'b00, 6'h00, D0);
        step(1'b1, 1'b1, 1'b0, 2'b00, 6'h00, D1);
        idle(D2);
        idle(D3);
        do_read(6'h0C, D2, "R5 beat2 address");
        do_read(6'h0D, D3, "R5 beat3 address");
        do_read(6'h0F, D1, "R5 beat1 address");
        // read burst from 0x0D: 0x0D,0x0C,0x0F,0x0E
        step(1'b0, 1'b0, 1'b1, 2'b11, 6'h0D, JUNK);
        step(1'b1, 1'b1, 1'b1, 2'b11, 6'h00, JUNK);
        chk("R5 read beat0", {14'd0, dq_out}, {14'd0, D3});
        step(1'b1, 1'b1, 1'b1, 2'b11, 6'h00, JUNK);
        chk("R5 read beat1", {14'd0, dq_out}, {14'd0, D2});
        step(1'b1, 1'b1, 1'b1, 2'b11, 6'h00, JUNK);
        chk("R2 read continue", {14'd0, dq_out}, {14'd0, D1});
        idle(JUNK);
        chk("R5 read beat3", {14'd0, dq_out}, {14'd0, D0});
    endtask

    task automatic t_oe;
        do_write(6'h20, E0, 2'b00);
        do_write(6'h21, E1, 2'b00);
        out_en_n = 1'b1;
        step(1'b0, 1'b0, 1'b1, 2'b11, 6'h20, JUNK);
        step(1'b1, 1'b1, 1'b1, 2'b11, 6'h00, JUNK);
        chk("R7 dummy read no drive", {31'd0, dq_drive}, 32'd0);
        #1 out_en_n = 1'b0;
        #1 chk("R7 async enable", {31'd0, dq_drive}, 32'd1);
        out_en_n = 1'b1;
        #1 chk("R7 async disable", {31'd0, dq_drive}, 32'd0);
        out_en_n = 1'b0;
        idle(JUNK);
        chk("R7 burst advanced", {14'd0, dq_out}, {14'd0, E1});
    endtask

    task automatic t_stall;
        step(1'b0, 1'b0, 1'b1, 2'b11, 6'h0C, JUNK);
        stall = 1'b1;
        step(1'b0, 1'b0, 1'b0, 2'b00, 6'h0C, JUNK);
        chk("R6 stalled edge no data", {31'd0, dq_drive}, 32'd0);
        stall = 1'b0;
        idle(JUNK);
        chk("R6 data after stall", {14'd0, dq_out}, {14'd0, D2});
        stall = 1'b1;
        idle(JUNK);
        chk("R6 data held", {14'd0, dq_out}, {14'd0, D2});
        stall = 1'b0;
        idle(JUNK);
        chk("R6 release", {31'd0, dq_drive}, 32'd0);
        step(1'b0, 1'b0, 1'b0, 2'b00, 6'h30, JUNK);
        idle(JUNK);
        stall = 1'b1;
        idle(JUNK);
        chk("R6 write phase held", {30'd0, lane_we}, 32'd3);
        stall = 1'b0;
        idle(E2);
        do_read(6'h30, E2, "R6 write after stall");
    endtask

    task automatic t_b2b;
        do_write(6'h10, E0, 2'b00);
        do_write(6'h11, E1, 2'b00);
        step(1'b0, 1'b0, 1'b1, 2'b11, 6'h10, JUNK);
        step(1'b0, 1'b0, 1'b0, 2'b00, 6'h12, JUNK);
        chk("R12 read then write", {14'd0, dq_out}, {14'd0, E0});
        step(1'b0, 1'b0, 1'b1, 2'b11, 6'h11, JUNK);
        chk("R12 write phase", {30'd0, lane_we}, 32'd3);
        idle(D3);
        chk("R12 read after write", {14'd0, dq_out}, {14'd0, E1});
        do_read(6'h12, D3, "R12 written word");
    endtask

    task automatic t_raw;
        step(1'b0, 1'b0, 1'b0, 2'b00, 6'h18, JUNK);
        step(1'b0, 1'b0, 1'b1, 2'b11, 6'h18, JUNK);
        idle(D0);
        chk("R11 forwarded data", {14'd0, dq_out}, {14'd0, D0});
    endtask

    task automatic t_desel;
        idle(JUNK);
        step(1'b0, 1'b1, 1'b0, 2'b00, 6'h30, JUNK);
        idle(JUNK);
        chk("R1 continue deselect no drive", {31'd0, dq_drive}, 32'd0);
        idle(JUNK);
        chk("R1 continue deselect no write", {30'd0, lane_we}, 32'd0);
        step(1'b1, 1'b0, 1'b0, 2'b00, 6'h30, JUNK);
        idle(JUNK);
        chk("R1 deselect no write", {30'd0, lane_we}, 32'd0);
        idle(JUNK);
        do_read(6'h30, E2, "R1 word unchanged");
    endtask

    task automatic t_sleep;
        do_write(6'h22, D1, 2'b00);
        do_write(6'h23, D2, 2'b00);
        step(1'b0, 1'b0, 1'b1, 2'b11, 6'h10, JUNK);
        idle(JUNK);
        chk("R8 drive before sleep", {31'd0, dq_drive}, 32'd1);
        sleep = 1'b1;
        #1 chk("R8 immediate release", {31'd0, dq_drive}, 32'd0);
        idle(JUNK);
        chk("R8 not yet asleep", {31'd0, asleep}, 32'd0);
        idle(JUNK);
        chk("R8 asleep after two edges", {31'd0, asleep}, 32'd1);
        idle(JUNK);
        sleep = 1'b0;
        step(1'b0, 1'b0, 1'b0, 2'b00, 6'h22, JUNK);
        chk("R9 awake", {31'd0, asleep}, 32'd0);
        step(1'b0, 1'b0, 1'b0, 2'b00, 6'h23, JUNK);
        chk("R9 recovery no write", {30'd0, lane_we}, 32'd0);
        step(1'b0, 1'b0, 1'b0, 2'b00, 6'h24, JUNK);
        idle(JUNK);
        idle(E0);
        do_read(6'h22, D1, "R9 first ignored");
        do_read(6'h23, D2, "R9 second ignored");
        do_read(6'h24, E0, "R9 third accepted");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; adv = 1'b0; wr_n = 1'b1; lane_n = 2'b11;
        stall = 1'b0; sleep = 1'b0; out_en_n = 1'b0; addr = '0; din = '0;
        repeat (3) @(posedge clk);
        #1 chk("R10 drive in reset", {31'd0, dq_drive}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_single();
        t_lanes();
        t_burst();
        t_oe();
        t_stall();
        t_b2b();
        t_raw();
        t_desel();
        t_sleep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule